// File: doc/BRIEF.md
# Serial Result Output Engine for a Delta-Sigma Converter

This block models the digital half of a delta-sigma converter's serial port when an external host supplies the serial clock. It moves through three named states. **CONVERT** stands in for the modulator with a cycle counter. **SLEEP** holds the finished 32-bit frame in a static shift register. **OUTPUT** shifts that frame out most significant bit first. The frame's top bit is the end-of-conversion flag, which is 0 when the frame is valid. The other 31 bits are the result, taken from a test input at the moment the conversion ends. The host reads `sdo` on rising serial-clock edges, and the block changes `sdo` after falling edges.

There are four transitions. **conv_done** goes from CONVERT to SLEEP once the conversion time has elapsed, whatever the chip select is doing. **first_rise** goes from SLEEP to OUTPUT on the first rising serial-clock edge. **word_end** goes from OUTPUT to CONVERT on the 32nd falling edge. **abort** goes from OUTPUT to CONVERT on a rising chip-select edge once at least five falling edges have been seen. The block can run with chip select held low permanently, giving a two-wire link. In that mode `sdo` shows the conversion status in both CONVERT and SLEEP. `sck` and `cs_n` are synchronised into the system clock with two flops, and their edges are detected in that domain. Bits arriving on `sdi` are sampled but have no effect.

Top module: `serial_result_port`

## Requirements
- R1: After reset the block is in CONVERT, with `busy` = 1 and `sdo` = 1.
- R2: CONVERT lasts exactly `CONV_CYCLES` clock cycles and is then followed by SLEEP with `busy` = 0. The frame is {1'b0, `result_in`}, with `result_in` sampled on the cycle SLEEP is entered. Later changes to `result_in` do not alter the held frame.
- R3: SLEEP persists, at any level of `cs_n`, until a synchronised rising edge of `sck`.
- R4: In SLEEP and OUTPUT, after k falling `sck` edges of the current read, `sdo` carries frame bit 31−k. Bit 31 (EOC = 0) is visible before the first rise, and bit 0 is visible before the 32nd rise.
- R5: The 32nd falling `sck` edge starts CONVERT, which drives `busy` = 1 and `sdo` = 1.
- R6: `sdo_oe` is the combinational inverse of `cs_n` in every state.
- R7: A rising `cs_n` edge in OUTPUT, after at least 5 falling `sck` edges, starts CONVERT at once.
- R8: A rising `cs_n` edge in OUTPUT with fewer than 5 falling edges is ignored. The read then continues and delivers the whole frame.
- R9: An `sck` or `cs_n` change takes effect on the third rising `clk` edge after it is applied.
- R10: `sdi` has no effect on `sdo` or `busy`.
- R11: `sck` activity during CONVERT neither shortens nor extends the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sdi | input | 1 | Host serial data in; sampled, no effect |
| result_in | input | WORD_BITS-1 | Conversion result to be framed |
| sdo | output | 1 | Serial data/status out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| busy | output | 1 | High while a conversion runs |

## Verification
Every serial-clock or chip-select change reaches the state register on the third rising `clk` edge, so `sdo` and `busy` move three cycles after the change. `sdo_oe` moves in the same cycle. The bench holds each `sck` level for five cycles and samples `sdo` on the falling `clk` edge just before it raises `sck`, which is always after the previous bit has settled. A behavioural model in the bench applies that same three-edge delay to its own view of the inputs and is compared with all three outputs on every falling `clk` edge. Separate directed checks probe the second and third cycles after a falling `sck` edge, to pin down the latency itself.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_OUTPUT  = 2'd2
    } srp_state_e;
endpackage

// File: rtl/srp_level_sync.sv
// Multi-stage synchroniser for one asynchronous level.
module srp_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
endmodule

// File: rtl/srp_conv_timer.sv
// Stand-in for the modulator: counts the conversion time.
module srp_conv_timer #(
    parameter int CONV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int TW = $clog2(CONV_CYCLES + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == TW'(CONV_CYCLES - 1));

    // R2
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);
endmodule

// File: rtl/srp_frame_shift.sv
// Static frame register with a falling-edge counter.
module srp_frame_shift #(
    parameter int WORD_BITS = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [WORD_BITS-2:0]           payload,
    input  logic                           shift,
    output logic                           bit_out,
    output logic [$clog2(WORD_BITS+1)-1:0] fall_cnt
);
    localparam int CW = $clog2(WORD_BITS + 1);

    logic [WORD_BITS-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word     <= '0;
            fall_cnt <= '0;
        end else if (load) begin
            word     <= {1'b0, payload};
            fall_cnt <= '0;
        end else if (shift) begin
            word     <= {word[WORD_BITS-2:0], 1'b0};
            fall_cnt <= fall_cnt + CW'(1);
        end
    end

    assign bit_out = word[WORD_BITS-1];

    // R4
    frame_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(bit_out));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
    parameter int CONV_CYCLES = 1000,
    parameter int WORD_BITS   = 32,
    parameter int ABORT_MIN   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 sdi,
    input  logic [WORD_BITS-2:0] result_in,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 busy
);
    import srp_pkg::*;

    localparam int CW      = $clog2(WORD_BITS + 1);
    localparam int CFG_W   = 5;

    srp_state_e state, nxt;

    logic sck_s, cs_s, sdi_s;
    logic sck_d, cs_d;
    logic sck_rise, sck_fall, cs_rise;
    logic conv_done, restart, load, shift, bit_out;
    logic [CW-1:0]    fall_cnt;
    logic [CFG_W-1:0] cfg_q;

    srp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .din(sck), .level(sck_s));
    srp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_s));
    srp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(sdi), .level(sdi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b0;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_s & ~cs_d;

    srp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .done(conv_done));

    srp_frame_shift #(.WORD_BITS(WORD_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .load(load), .payload(result_in),
        .shift(shift), .bit_out(bit_out), .fall_cnt(fall_cnt));

    // Next-state and datapath strobes
    always_comb begin
        nxt     = state;
        load    = 1'b0;
        shift   = 1'b0;
        restart = 1'b0;
        unique case (state)
            ST_CONVERT: begin
                if (conv_done) begin
                    nxt  = ST_SLEEP;
                    load = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (sck_rise) nxt = ST_OUTPUT;
            end
            ST_OUTPUT: begin
                if (cs_rise && fall_cnt >= CW'(ABORT_MIN)) begin
                    nxt     = ST_CONVERT;
                    restart = 1'b1;
                end else if (sck_fall) begin
                    if (fall_cnt == CW'(WORD_BITS - 1)) begin
                        nxt     = ST_CONVERT;
                        restart = 1'b1;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: begin
                nxt     = ST_CONVERT;
                restart = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CONVERT;
        else        state <= nxt;
    end

    // Speed/resolution bits: sampled, never acted upon
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else if (state == ST_OUTPUT && sck_rise && fall_cnt < CW'(CFG_W))
            cfg_q <= {cfg_q[CFG_W-2:0], sdi_s};
    end

    // Outputs
    always_comb begin
        busy   = (state == ST_CONVERT);
        sdo    = (state == ST_CONVERT) ? 1'b1 : bit_out;
        sdo_oe = ~cs_n;
    end

    // R2
    conv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && conv_done) |=> (state == ST_SLEEP && !busy));
    // R3
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !sck_rise) |=> (state == ST_SLEEP));
    // R5
    word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTPUT && sck_fall && !cs_rise && fall_cnt == CW'(WORD_BITS - 1))
        |=> (busy && sdo));
    // R7
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTPUT && cs_rise && fall_cnt >= CW'(ABORT_MIN)) |=> busy);
    // R8
    early_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTPUT && cs_rise && !sck_fall && fall_cnt < CW'(ABORT_MIN))
        |=> (state == ST_OUTPUT));
    // R11
    conv_nosck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && !conv_done) |=> (state == ST_CONVERT));
    // R10
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OUTPUT) |=> $stable(cfg_q));
endmodule

// File: tb/serial_result_port_test.sv
module serial_result_port_test;
    localparam int CONV = 40;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b0;
    logic        sdi = 1'b0;
    logic [30:0] result_in = 31'h2AAA_5555;
    logic        sdo, sdo_oe, busy;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    serial_result_port #(.CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .result_in(result_in), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy));

    // Behavioural reference: 0 converting, 1 sleeping, 2 shifting
    int          mstate, mcyc, mfall;
    logic [31:0] mframe;
    logic [2:0]  qs, qc;

    always @(posedge clk) begin
        if (!rst_n) begin
            mstate = 0; mcyc = 0; mfall = 0; mframe = '0; qs = '0; qc = '0;
        end else begin
            bit r, f, cr;
            r  = qs[1] && !qs[2];
            f  = !qs[1] && qs[2];
            cr = qc[1] && !qc[2];
            case (mstate)
                0: if (mcyc == CONV - 1) begin
                       mstate = 1; mframe = {1'b0, result_in}; mfall = 0;
                   end else mcyc++;
                1: if (r) mstate = 2;
                default: begin
                    if (cr && mfall >= 5) begin mstate = 0; mcyc = 0; end
                    else if (f) begin
                        if (mfall == 31) begin mstate = 0; mcyc = 0; end
                        else mfall++;
                    end
                end
            endcase
            qs = {qs[1:0], sck};
            qc = {qc[1:0], cs_n};
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic eb, es;
            eb = (mstate == 0);
            es = (mstate == 0) ? 1'b1 : mframe[31 - mfall];
            chk(busy === eb, "R2 busy", {31'd0, busy}, {31'd0, eb});
            chk(sdo_oe === !cs_n, "R6 sdo_oe", {31'd0, sdo_oe}, {31'd0, !cs_n});
            if (sdo_oe) chk(sdo === es, "R4 sdo", {31'd0, sdo}, {31'd0, es});
        end
    end

    task automatic wait_sleep();
        int n = 0;
        while (busy !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic read_bits(input int start, input int n, input logic [31:0] pat,
                             inout logic [31:0] got);
        for (int i = 0; i < n; i++) begin
            got[31 - (start + i)] = sdo;
            sdi = pat[31 - (start + i)];
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w1, w2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b1 && sdo === 1'b1, "R1 reset", {30'd0, busy, sdo}, 32'd3);

        // R11 serial clocking during conversion does not end it
        read_bits(0, 2, 32'h0, w1);
        chk(busy === 1'b1, "R11 conv busy", {31'd0, busy}, 32'd1);
        wait_sleep();

        // R3 sleep holds with cs high
        cs_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(busy === 1'b0, "R3 sleep hold", {31'd0, busy}, 32'd0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sdo === 1'b0, "R6 status on sdo", {31'd0, sdo}, 32'd0);

        // R4 full read, R5 restart
        read_bits(0, 32, 32'hF0F0_3C3C, w1);
        chk(w1 === {1'b0, 31'h2AAA_5555}, "R4 word", w1, {1'b0, 31'h2AAA_5555});
        chk(busy === 1'b1 && sdo === 1'b1, "R5 restart", {30'd0, busy, sdo}, 32'd3);

        // R10 different sdi pattern, same data
        wait_sleep();
        read_bits(0, 32, 32'h0F0F_C3C3, w2);
        chk(w2 === w1, "R10 sdi ignored", w2, w1);

        // R7 abort after five falls
        result_in = 31'h1357_9BDF;
        wait_sleep();
        read_bits(0, 5, 32'h0, w1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy === 1'b1, "R7 abort", {31'd0, busy}, 32'd1);
        cs_n = 1'b0;

        // R8 early cs pulse ignored; R2 held frame
        wait_sleep();
        result_in = 31'h7FFF_0000;
        read_bits(0, 2, 32'h0, w1);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy === 1'b0, "R8 no abort", {31'd0, busy}, 32'd0);
        read_bits(2, 30, 32'h0, w1);
        chk(w1 === {1'b0, 31'h1357_9BDF}, "R8 R2 word held", w1, {1'b0, 31'h1357_9BDF});

        // R9 latency of one falling edge
        result_in = 31'h5A5A_1234;
        wait_sleep();
        w1[31] = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(sdo === 1'b0, "R9 not yet", {31'd0, sdo}, 32'd0);
        @(negedge clk);
        chk(sdo === 1'b1, "R9 third edge", {31'd0, sdo}, 32'd1);
        repeat (HALF - 3) @(negedge clk);
        read_bits(1, 31, 32'h0, w1);
        chk(w1 === {1'b0, 31'h5A5A_1234}, "R4 word 2", w1, {1'b0, 31'h5A5A_1234});

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule